// File: doc/BRIEF.md
# Bridge Address Window Policy Classifier

This block sits at the seam between a processor's internal bus and an external point-to-point I/O link. It holds four banks of programmable address windows: receive, post, prefetch and uncache. Each bank has several base/mask/enable entries. Every transaction is classified against the banks that apply to its direction, and the result travels with it through a single registered stage.

Traffic coming in from the link is sent either to the internal bus or back out to the link as peer-to-peer traffic. Inbound traffic that reaches the internal bus is also tagged as cacheable or uncached. Traffic going out from the internal bus can go three ways:
- a write is issued on the link as posted, which gives the processor an early completion pulse, or as non-posted;
- a speculative or instruction-fetch read is either forwarded to the link or answered locally with a dummy all-ones response;
- a plain read always goes to the link.

Both request paths and the local response path use valid/ready handshakes. A stage accepts a new request when it is empty, or when its held result leaves in the same cycle. An output that is held back keeps its payload stable until it is taken. Window registers are loaded through a plain write port.

Top module: `bridge_window_policy`

## Requirements
- R1: A window hits when its enable bit is set and (addr & mask) == (base & mask). After reset every window has base 0, mask 0 and is disabled, so no window of any bank hits.
- R2: With `mode_device` = 0 (bridge mode), an inbound request that hits any receive window leaves with `ibo_p2p` = 0, meaning it is routed to the internal bus.
- R3: In bridge mode, an inbound request that misses every receive window leaves with `ibo_p2p` = 1, meaning it is reflected back onto the link.
- R4: With `mode_device` = 1, every inbound request leaves with `ibo_p2p` = 0, whatever the receive windows hold.
- R5: An inbound request routed to the internal bus carries `ibo_uncached` = 1 when it hits an uncache window and 0 otherwise. A reflected request always carries 0.
- R6: Outbound kind encoding is 0 = read, 1 = write, 2 = speculative read, 3 = instruction fetch. A write that hits a post window is issued with `lk_posted` = 1. `wr_done` pulses in exactly the cycle in which that write is handed over on the link (`lk_valid` and `lk_ready` both high). A write that misses every post window has `lk_posted` = 0 and never raises `wr_done`.
- R7: A speculative read or fetch (kind 2 or 3) that misses every prefetch window never reaches the link. It appears on the response channel in the cycle after acceptance, with `rsp_data` all ones and `rsp_status` = 2'b00 (OK).
- R8: A speculative read or fetch that hits a prefetch window goes to the link, and so does every plain read (kind 0) and every write. None of these produces a local response.
- R9: Each direction has exactly one register stage. A request accepted at a clock edge is presented at the output after that edge and not before. `ib_ready`/`ob_ready` are high when the stage is empty or its output is being taken. A stalled output holds its payload stable. Both are idle after reset.
- R10: A window write affects only requests accepted at later edges. A request accepted at the same edge as the write is classified with the old settings.
- R11: The configuration write selects a bank by `cfg_type` (0 receive, 1 post, 2 prefetch, 3 uncache), an entry by `cfg_idx`, and a field by `cfg_field` (0 base, 1 mask, 2 enable taken from `cfg_wdata[0]`). Field code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_device | input | 1 | 1 = device mode, 0 = bridge mode |
| cfg_we | input | 1 | Window register write strobe |
| cfg_type | input | 2 | Bank select |
| cfg_idx | input | 2 | Entry select within the bank |
| cfg_field | input | 2 | Field select |
| cfg_wdata | input | 32 | Write data |
| ib_valid | input | 1 | Inbound request valid |
| ib_ready | output | 1 | Inbound request accepted |
| ib_addr | input | 32 | Inbound address |
| ib_write | input | 1 | Inbound request is a write |
| ibo_valid | output | 1 | Classified inbound valid |
| ibo_ready | input | 1 | Classified inbound taken |
| ibo_addr | output | 32 | Classified inbound address |
| ibo_write | output | 1 | Classified inbound write flag |
| ibo_p2p | output | 1 | Reflect back onto the link |
| ibo_uncached | output | 1 | Access memory uncached |
| ob_valid | input | 1 | Outbound request valid |
| ob_ready | output | 1 | Outbound request accepted |
| ob_addr | input | 32 | Outbound address |
| ob_kind | input | 2 | Outbound request kind |
| lk_valid | output | 1 | Link request valid |
| lk_ready | input | 1 | Link request taken |
| lk_addr | output | 32 | Link request address |
| lk_kind | output | 2 | Link request kind |
| lk_posted | output | 1 | Write is posted |
| rsp_valid | output | 1 | Local dummy response valid |
| rsp_ready | input | 1 | Local dummy response taken |
| rsp_data | output | 64 | Dummy response data |
| rsp_status | output | 2 | Dummy response status |
| wr_done | output | 1 | Early completion for a posted write |

## Verification
The hardest case to reach from the ports is a window write landing at the very edge at which a request is accepted. The old/new boundary of R10 only shows up then. The bench drives the configuration strobe and the request valid in the same half-cycle. Against an empty stage, that makes the write and the acceptance coincide at one edge. The bench then sends the same request again to see the new classification. Stalled outputs are reached by holding the downstream ready low while a second request waits, and then releasing it.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  typedef enum logic [1:0] {
    WIN_RECV = 2'd0,
    WIN_POST = 2'd1,
    WIN_PREF = 2'd2,
    WIN_UNC  = 2'd3
  } win_type_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_EN   = 2'd2,
    FLD_RSVD = 2'd3
  } win_field_e;

  typedef enum logic [1:0] {
    OB_READ  = 2'd0,
    OB_WRITE = 2'd1,
    OB_SPEC  = 2'd2,
    OB_FETCH = 2'd3
  } ob_kind_e;

  localparam int NUM_WIN_TYPES = 4;
  localparam logic [1:0] RSP_OK = 2'b00;

  function automatic logic kind_is_spec(input logic [1:0] k);
    return (k == OB_SPEC) || (k == OB_FETCH);
  endfunction
endpackage

// File: rtl/bwp_window_bank.sv
module bwp_window_bank
  import bwp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] mask_q;
  logic [NUM_WIN-1:0]             en_q;
  logic [NUM_WIN-1:0]             match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (wr_idx == IDX_W'(w)) begin
          case (wr_field)
            FLD_BASE: base_q[w] <= wr_data;
            FLD_MASK: mask_q[w] <= wr_data;
            FLD_EN:   en_q[w]   <= wr_data[0];
            default:  ;
          endcase
        end
      end
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign match[w] = en_q[w] &&
                      ((probe_addr & mask_q[w]) == (base_q[w] & mask_q[w]));
  end

  assign hit = |match;

  // R1: a hit needs some enabled entry
  a_r1_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en_q != '0));

  // R11: the reserved field code leaves every entry untouched
  a_r11_rsvd_field_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == FLD_RSVD) |=>
      ($stable(base_q) && $stable(mask_q) && $stable(en_q)));
endmodule

// File: rtl/bwp_ib_stage.sv
module bwp_ib_stage
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_device,
  input  logic              recv_hit,
  input  logic              unc_hit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output logic              out_p2p,
  output logic              out_uncached
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q, p2p_q, unc_q;
  logic              load, p2p_n, unc_n;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;
  assign p2p_n    = !mode_device && !recv_hit;
  assign unc_n    = unc_hit && !p2p_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      write_q <= 1'b0;
      p2p_q   <= 1'b0;
      unc_q   <= 1'b0;
    end else if (load) begin
      vld_q   <= 1'b1;
      addr_q  <= in_addr;
      write_q <= in_write;
      p2p_q   <= p2p_n;
      unc_q   <= unc_n;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid    = vld_q;
  assign out_addr     = addr_q;
  assign out_write    = write_q;
  assign out_p2p      = p2p_q;
  assign out_uncached = unc_q;

  // R9: a stalled inbound result keeps its payload
  a_r9_ib_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_p2p) && $stable(out_uncached)));

  // R9: accepted request appears after the edge
  a_r9_ib_present: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4: device mode never reflects
  a_r4_device_no_p2p: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_device) |=> !out_p2p);

  // R3: bridge-mode miss is reflected
  a_r3_miss_reflect: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode_device && !recv_hit) |=> (out_p2p && !out_uncached));

  // R2: bridge-mode hit goes inward
  a_r2_hit_inward: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && recv_hit) |=> !out_p2p);
endmodule

// File: rtl/bwp_ob_stage.sv
module bwp_ob_stage
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_hit,
  input  logic              pref_hit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [ADDR_W-1:0] lk_addr,
  output logic [1:0]        lk_kind,
  output logic              lk_posted,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_status,
  output logic              wr_done
);
  logic              vld_q, local_q, posted_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        kind_q;
  logic              drain, load, local_n, posted_n;

  assign local_n  = kind_is_spec(req_kind) && !pref_hit;
  assign posted_n = (req_kind == OB_WRITE) && post_hit;
  assign drain    = local_q ? rsp_ready : lk_ready;
  assign req_ready = !vld_q || drain;
  assign load     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      local_q  <= 1'b0;
      posted_q <= 1'b0;
      addr_q   <= '0;
      kind_q   <= OB_READ;
    end else if (load) begin
      vld_q    <= 1'b1;
      local_q  <= local_n;
      posted_q <= posted_n;
      addr_q   <= req_addr;
      kind_q   <= req_kind;
    end else if (drain) begin
      vld_q <= 1'b0;
    end
  end

  assign lk_valid   = vld_q && !local_q;
  assign lk_addr    = addr_q;
  assign lk_kind    = kind_q;
  assign lk_posted  = posted_q;
  assign rsp_valid  = vld_q && local_q;
  assign rsp_data   = '1;
  assign rsp_status = RSP_OK;
  assign wr_done    = lk_valid && lk_ready && posted_q;

  // R9: one destination at a time
  a_r9_ob_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_valid, rsp_valid}));

  // R9: a stalled link request keeps its payload
  a_r9_lk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |=>
      (lk_valid && $stable(lk_addr) && $stable(lk_kind) && $stable(lk_posted)));

  // R7: unprefetchable speculative read is answered locally next cycle
  a_r7_local_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && kind_is_spec(req_kind) && !pref_hit) |=>
      (rsp_valid && !lk_valid));

  // R8: non-speculative requests always go to the link
  a_r8_nonspec_link: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !kind_is_spec(req_kind)) |=> (lk_valid && !rsp_valid));

  // R6: early completion only for a write handed to the link
  a_r6_done_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (lk_kind == OB_WRITE && lk_valid && lk_ready));

  // R6: post-window miss stays non-posted
  a_r6_miss_nonposted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == OB_WRITE && !post_hit) |=> !lk_posted);
endmodule

// File: rtl/bridge_window_policy.sv
module bridge_window_policy
  import bwp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_device,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_type,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              ib_valid,
  output logic              ib_ready,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic              ib_write,
  output logic              ibo_valid,
  input  logic              ibo_ready,
  output logic [ADDR_W-1:0] ibo_addr,
  output logic              ibo_write,
  output logic              ibo_p2p,
  output logic              ibo_uncached,
  input  logic              ob_valid,
  output logic              ob_ready,
  input  logic [ADDR_W-1:0] ob_addr,
  input  logic [1:0]        ob_kind,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [ADDR_W-1:0] lk_addr,
  output logic [1:0]        lk_kind,
  output logic              lk_posted,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_status,
  output logic              wr_done
);
  logic [NUM_WIN_TYPES-1:0] type_hit;

  for (genvar t = 0; t < NUM_WIN_TYPES; t++) begin : g_bank
    localparam bit INBOUND = (t == int'(WIN_RECV)) || (t == int'(WIN_UNC));
    logic [ADDR_W-1:0] probe;
    assign probe = INBOUND ? ib_addr : ob_addr;

    bwp_window_bank #(
      .ADDR_W (ADDR_W),
      .NUM_WIN(NUM_WIN)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_type == 2'(t))),
      .wr_idx    (cfg_idx),
      .wr_field  (cfg_field),
      .wr_data   (cfg_wdata),
      .probe_addr(probe),
      .hit       (type_hit[t])
    );
  end

  bwp_ib_stage #(.ADDR_W(ADDR_W)) u_ib (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_device (mode_device),
    .recv_hit    (type_hit[WIN_RECV]),
    .unc_hit     (type_hit[WIN_UNC]),
    .in_valid    (ib_valid),
    .in_ready    (ib_ready),
    .in_addr     (ib_addr),
    .in_write    (ib_write),
    .out_valid   (ibo_valid),
    .out_ready   (ibo_ready),
    .out_addr    (ibo_addr),
    .out_write   (ibo_write),
    .out_p2p     (ibo_p2p),
    .out_uncached(ibo_uncached)
  );

  bwp_ob_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ob (
    .clk       (clk),
    .rst_n     (rst_n),
    .post_hit  (type_hit[WIN_POST]),
    .pref_hit  (type_hit[WIN_PREF]),
    .req_valid (ob_valid),
    .req_ready (ob_ready),
    .req_addr  (ob_addr),
    .req_kind  (ob_kind),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_addr   (lk_addr),
    .lk_kind   (lk_kind),
    .lk_posted (lk_posted),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_status(rsp_status),
    .wr_done   (wr_done)
  );

  // R5: reflected traffic is never tagged uncached
  a_r5_p2p_not_uncached: assert property (@(posedge clk) disable iff (!rst_n)
    ibo_valid |-> !(ibo_p2p && ibo_uncached));
endmodule

// File: tb/bridge_window_policy_test.sv
module bridge_window_policy_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_device = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_type = '0, cfg_idx = '0, cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ib_valid = 1'b0, ib_write = 1'b0, ibo_ready = 1'b1;
  logic [31:0] ib_addr = '0;
  logic        ob_valid = 1'b0, lk_ready = 1'b1, rsp_ready = 1'b1;
  logic [31:0] ob_addr = '0;
  logic [1:0]  ob_kind = '0;
  logic        ib_ready, ibo_valid, ibo_write, ibo_p2p, ibo_uncached;
  logic [31:0] ibo_addr, lk_addr;
  logic        ob_ready, lk_valid, lk_posted, rsp_valid, wr_done;
  logic [1:0]  lk_kind, rsp_status;
  logic [63:0] rsp_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bridge_window_policy uut (
    .clk(clk), .rst_n(rst_n), .mode_device(mode_device),
    .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_addr(ib_addr), .ib_write(ib_write),
    .ibo_valid(ibo_valid), .ibo_ready(ibo_ready), .ibo_addr(ibo_addr),
    .ibo_write(ibo_write), .ibo_p2p(ibo_p2p), .ibo_uncached(ibo_uncached),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_addr(ob_addr), .ob_kind(ob_kind),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_kind(lk_kind),
    .lk_posted(lk_posted), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_status(rsp_status), .wr_done(wr_done)
  );

  // bench-side window model
  logic [31:0] mb [4][4];
  logic [31:0] mm [4][4];
  logic        me [4][4];

  function automatic logic mhit(input int t, input logic [31:0] a);
    logic h = 1'b0;
    for (int i = 0; i < 4; i++)
      if (me[t][i] && ((a & mm[t][i]) == (mb[t][i] & mm[t][i]))) h = 1'b1;
    return h;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_wr(input int t, input int i, input int f, input logic [31:0] d);
    if (f == 0) mb[t][i] = d;
    else if (f == 1) mm[t][i] = d;
    else if (f == 2) me[t][i] = d[0];
  endtask

  task automatic cfg_wr(input int t, input int i, input int f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_type = 2'(t); cfg_idx = 2'(i); cfg_field = 2'(f); cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    model_wr(t, i, f, d);
  endtask

  task automatic ib_xfer(input logic [31:0] a, input logic w, input logic md);
    logic rh, uh, p2p;
    rh = mhit(0, a); uh = mhit(3, a);
    p2p = !md && !rh;
    @(negedge clk);
    check("R9", "ib stage empty before send", 64'(ibo_valid), 64'd0);
    mode_device = md; ib_valid = 1'b1; ib_addr = a; ib_write = w; ibo_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ib_valid = 1'b0;
    check("R9", "ib out valid", 64'(ibo_valid), 64'd1);
    check("R9", "ib addr", 64'(ibo_addr), 64'(a));
    check("R9", "ib write flag", 64'(ibo_write), 64'(w));
    check(md ? "R4" : (rh ? "R2" : "R3"), "ib p2p", 64'(ibo_p2p), 64'(p2p));
    check("R5", "ib uncached", 64'(ibo_uncached), 64'(uh && !p2p));
  endtask

  task automatic ob_xfer(input logic [31:0] a, input logic [1:0] k);
    logic spec, loc, post;
    spec = k[1];
    loc  = spec && !mhit(2, a);
    post = (k == 2'd1) && mhit(1, a);
    @(negedge clk);
    check("R9", "ob stage empty before send", 64'(lk_valid | rsp_valid), 64'd0);
    ob_valid = 1'b1; ob_addr = a; ob_kind = k; lk_ready = 1'b1; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ob_valid = 1'b0;
    check(loc ? "R7" : "R8", "lk_valid", 64'(lk_valid), 64'(!loc));
    check(loc ? "R7" : "R8", "rsp_valid", 64'(rsp_valid), 64'(loc));
    if (loc) begin
      check("R7", "rsp_data", rsp_data, {64{1'b1}});
      check("R7", "rsp_status", 64'(rsp_status), 64'd0);
    end else begin
      check("R8", "lk_addr", 64'(lk_addr), 64'(a));
      check("R8", "lk_kind", 64'(lk_kind), 64'(k));
      check("R6", "lk_posted", 64'(lk_posted), 64'(post));
      check("R6", "wr_done", 64'(wr_done), 64'(post));
    end
  endtask

  function automatic logic [31:0] offs(input int o);
    case (o)
      0: return 32'h0;
      1: return 32'h0FF;
      2: return 32'h100;
      3: return 32'hFFF;
      4: return 32'h1000;
      5: return 32'hFFFF;
      default: return 32'h10000;
    endcase
  endfunction

  function automatic logic [31:0] wbase(input int t, input int i);
    return 32'h1000_0000 * (t + 1) + 32'h0010_0000 * i;
  endfunction

  function automatic logic [31:0] wmask(input int i);
    case (i)
      0: return 32'hFFFF_F000;
      1: return 32'hFFFF_0000;
      2: return 32'hFFFF_FF00;
      default: return 32'hFFFF_F000;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] a0, a1;
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 4; i++) begin
        mb[t][i] = '0; mm[t][i] = '0; me[t][i] = 1'b0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "reset ibo_valid", 64'(ibo_valid), 64'd0);
    check("R9", "reset lk_valid", 64'(lk_valid), 64'd0);
    check("R9", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9", "reset wr_done", 64'(wr_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "ib_ready idle", 64'(ib_ready), 64'd1);
    check("R9", "ob_ready idle", 64'(ob_ready), 64'd1);

    // R1: nothing hits after reset
    ib_xfer(32'h1234_5678, 1'b0, 1'b0);
    ib_xfer(32'h0000_0000, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) ob_xfer(32'h0000_0000, 2'(k));

    // R10: window enable lands on the same edge as a request
    @(negedge clk);
    cfg_we = 1'b1; cfg_type = 2'd1; cfg_idx = 2'd0; cfg_field = 2'd2; cfg_wdata = 32'd1;
    ob_valid = 1'b1; ob_addr = 32'h4444_0000; ob_kind = 2'd1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; ob_valid = 1'b0;
    check("R10", "same-edge write sees old window", 64'(lk_posted), 64'd0);
    model_wr(1, 0, 2, 32'd1);
    ob_xfer(32'h4444_0000, 2'd1);
    cfg_wr(1, 0, 2, 32'd0);
    ob_xfer(32'h4444_0000, 2'd1);

    // R11: reserved field code changes nothing
    for (int t = 0; t < 4; t++) cfg_wr(t, 1, 3, 32'hFFFF_FFFF);
    ib_xfer(32'h5555_5555, 1'b0, 1'b0);
    ob_xfer(32'h5555_5555, 2'd2);
    ob_xfer(32'h5555_5555, 2'd1);

    // program every bank; low base bits are junk below the mask
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 4; i++) begin
        cfg_wr(t, i, 0, wbase(t, i) + 32'h0AB);
        cfg_wr(t, i, 1, wmask(i));
        cfg_wr(t, i, 2, (i == 3) ? 32'd0 : 32'd1);
      end

    // sweep: every window, several offsets, both modes, every kind
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 4; i++)
        for (int o = 0; o < 7; o++) begin
          a0 = wbase(t, i) + offs(o);
          ib_xfer(a0, 1'(o), 1'b0);
          ib_xfer(a0, 1'(o), 1'b1);
          for (int k = 0; k < 4; k++) ob_xfer(a0, 2'(k));
        end

    // R9 inbound back-pressure
    a0 = wbase(0, 0); a1 = wbase(3, 0);
    @(negedge clk);
    mode_device = 1'b0; ibo_ready = 1'b0;
    ib_valid = 1'b1; ib_addr = a0; ib_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ib_addr = a1;
    check("R9", "ib_ready low when full and stalled", 64'(ib_ready), 64'd0);
    repeat (3) @(negedge clk);
    check("R9", "stalled ib addr held", 64'(ibo_addr), 64'(a0));
    check("R9", "stalled ib valid", 64'(ibo_valid), 64'd1);
    ibo_ready = 1'b1;
    #1;
    check("R9", "ib_ready when output taken", 64'(ib_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    ib_valid = 1'b0;
    check("R9", "next ib after release", 64'(ibo_addr), 64'(a1));
    check("R3", "uncache window not receive window reflects", 64'(ibo_p2p), 64'd1);

    // R9/R6 outbound back-pressure on a posted write
    a0 = wbase(1, 0);
    @(negedge clk);
    lk_ready = 1'b0;
    ob_valid = 1'b1; ob_addr = a0; ob_kind = 2'd1;
    @(posedge clk);
    @(negedge clk);
    ob_valid = 1'b0;
    check("R6", "no early completion while stalled", 64'(wr_done), 64'd0);
    check("R9", "ob_ready low when stalled", 64'(ob_ready), 64'd0);
    @(negedge clk);
    check("R9", "stalled lk addr held", 64'(lk_addr), 64'(a0));
    lk_ready = 1'b1;
    #1;
    check("R6", "early completion on hand-over", 64'(wr_done), 64'd1);
    @(negedge clk);
    check("R6", "single completion pulse", 64'(wr_done), 64'd0);

    // R7 local response held under rsp back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    ob_valid = 1'b1; ob_addr = 32'hE000_0000; ob_kind = 2'd3;
    @(posedge clk);
    @(negedge clk);
    ob_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", "held local response", 64'(rsp_valid), 64'd1);
    check("R7", "no link request for local read", 64'(lk_valid), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R7", "response drained", 64'(rsp_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule